// File: doc/BRIEF.md
# Speaker Limiter Gain Controller

This block is a digital automatic level controller for a speaker output path. It watches signed audio samples that arrive with a sample strobe and keeps an attenuation code counted in 0.5 dB units. When a sample's magnitude reaches an upper threshold, attenuation grows quickly. When the magnitude stays under a lower threshold, the gain returns slowly, one 1 dB step at a time. Each recovery step waits for a zero crossing of the signal, and a timeout applies the step if no crossing comes. Between the two thresholds nothing changes.

Applying the code to the audio is left to a downstream gain stage. The controller runs only while the power-down input is released and the amplifier enable is high. Each time both become true, it first sits through a fixed initialization interval counted in samples. It reports that interval, and any disabled period, on a busy flag.

Top module: `spk_limiter_ctrl`

## Requirements
- R1: During reset `att_code` is 0 and `init_busy` is 1.
- R2: While `pd_n` and `amp_en` are both 1 and the controller is not yet running, it counts strobed samples. On the INIT_LEN-th sample `init_busy` falls. Until then `att_code` stays 0 whatever the samples are.
- R3: The sample magnitude is the two's-complement absolute value. The most negative code is treated as the largest positive value. A sample is "hot" when its magnitude is at least HI_THR and "cold" when it is below LO_THR.
- R4: In a run of hot samples, the first hot sample raises `att_code` by 1 at once, without waiting for a zero crossing. A further +1 follows every LIM_PERIOD hot samples.
- R5: `att_code` never exceeds ATT_MAX. Hot samples at ATT_MAX leave it unchanged.
- R6: A sample with magnitude in [LO_THR, HI_THR) changes nothing, and it restarts the recovery count.
- R7: With `att_code` non-zero, a run of cold samples that are all zero crossings lowers `att_code` by 2 (1 dB) on every REC_PERIOD-th cold sample.
- R8: A sample is a zero crossing when it equals 0, or when its sign bit differs from that of the previous strobed sample.
- R9: Once REC_PERIOD cold samples have been counted, the step waits for a zero crossing. If none arrives, the step is applied on cold sample number 2*REC_PERIOD-1.
- R10: Recovery stops at `att_code` = 0. A step from 1 lands on 0.
- R11: When `pd_n` or `amp_en` is 0, after the next clock `att_code` is 0 and `init_busy` is 1. Re-enabling restarts the initialization interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_n | input | 1 | Power-down release, 1 = powered |
| amp_en | input | 1 | Amplifier enable |
| smp_vld | input | 1 | Sample strobe, one clock per sample |
| smp_data | input | DW | Signed two's-complement audio sample |
| att_code | output | ATT_W | Attenuation in 0.5 dB steps |
| init_busy | output | 1 | 1 while disabled or initializing |

## Verification
The limiter is driven with hot samples of both signs. These include the exact threshold and the most negative code, which shows whether the magnitude and the inclusive comparison are right. Recovery is tried three ways. Zeros interleaved with positive samples test the zero-equals-crossing rule. Alternating signs show the plain period. A constant positive tone can only step through the timeout, so it separates the timeout from zero-crossing gating. Dead-band samples, including one exactly at the lower threshold, must leave the code frozen. Disabling through each control input checks that the code clears and that initialization starts again.

// File: rtl/spk_limiter_ctrl.sv
module spk_limiter_ctrl #(
  parameter int DW         = 16,
  parameter int ATT_MAX    = 48,
  parameter int ATT_W      = $clog2(ATT_MAX + 1),
  parameter int LIM_PERIOD = 2,
  parameter int REC_PERIOD = 2048,
  parameter int INIT_LEN   = 2048,
  parameter int HI_THR     = 26028,
  parameter int LO_THR     = 20675
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_n,
  input  logic             amp_en,
  input  logic             smp_vld,
  input  logic [DW-1:0]    smp_data,
  output logic [ATT_W-1:0] att_code,
  output logic             init_busy
);
  localparam int INIT_W = $clog2(INIT_LEN);
  localparam int REC_W  = $clog2(REC_PERIOD);
  localparam int LIM_W  = $clog2(LIM_PERIOD);

  logic              run;
  logic [INIT_W-1:0] init_cnt;
  logic [LIM_W-1:0]  lim_cnt;
  logic [REC_W-1:0]  rec_cnt;
  logic [REC_W-1:0]  wait_cnt;
  logic              prev_neg;

  wire          active = pd_n & amp_en;
  wire          neg    = smp_data[DW-1];
  wire [DW-1:0] negv   = ~smp_data + 1'b1;
  wire [DW-1:0] mag    = !neg ? smp_data :
                         (smp_data == {1'b1, {(DW-1){1'b0}}}) ? {1'b0, {(DW-1){1'b1}}} : negv;
  wire          hot    = mag >= DW'(HI_THR);
  wire          cold   = mag <  DW'(LO_THR);
  wire          zc     = (smp_data == '0) || (neg != prev_neg);

  assign init_busy = ~run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= 1'b0;
      init_cnt <= '0;
      lim_cnt  <= '0;
      rec_cnt  <= '0;
      wait_cnt <= '0;
      prev_neg <= 1'b0;
      att_code <= '0;
    end else if (!active || !run) begin
      att_code <= '0;
      lim_cnt  <= '0;
      rec_cnt  <= '0;
      wait_cnt <= '0;
      prev_neg <= 1'b0;
      if (!active) begin
        run      <= 1'b0;
        init_cnt <= '0;
      end else if (smp_vld) begin
        if (init_cnt == INIT_W'(INIT_LEN - 1)) begin
          run      <= 1'b1;
          init_cnt <= '0;
        end else begin
          init_cnt <= init_cnt + 1'b1;
        end
      end
    end else if (smp_vld) begin
      prev_neg <= neg;
      if (hot) begin
        lim_cnt <= (lim_cnt == LIM_W'(LIM_PERIOD - 1)) ? '0 : lim_cnt + 1'b1;
        if (lim_cnt == '0 && att_code != ATT_W'(ATT_MAX))
          att_code <= att_code + 1'b1;
      end else begin
        lim_cnt <= '0;
      end
      if (cold && att_code != '0) begin
        if (rec_cnt != REC_W'(REC_PERIOD - 1)) begin
          rec_cnt <= rec_cnt + 1'b1;
        end else if (zc || wait_cnt == REC_W'(REC_PERIOD - 1)) begin
          att_code <= (att_code > ATT_W'(1)) ? att_code - ATT_W'(2) : '0;
          rec_cnt  <= '0;
          wait_cnt <= '0;
        end else begin
          wait_cnt <= wait_cnt + 1'b1;
        end
      end else begin
        rec_cnt  <= '0;
        wait_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/spk_limiter_ctrl_chk.sv
module spk_limiter_ctrl_chk #(
  parameter int ATT_MAX = 48,
  parameter int ATT_W   = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pd_n,
  input logic             amp_en,
  input logic             smp_vld,
  input logic [ATT_W-1:0] att_code,
  input logic             init_busy
);
  assert_att_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(att_code) <= ATT_MAX);

  assert_busy_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |-> att_code == '0);

  assert_rise_on_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (att_code > $past(att_code)) |-> ($past(smp_vld) && int'(att_code) == int'($past(att_code)) + 1));

  assert_fall_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (att_code < $past(att_code)) |-> (att_code == '0 || int'(att_code) == int'($past(att_code)) - 2));

  assert_disable_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(pd_n && amp_en) |=> (init_busy && att_code == '0));
endmodule

bind spk_limiter_ctrl spk_limiter_ctrl_chk #(.ATT_MAX(ATT_MAX), .ATT_W(ATT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .amp_en(amp_en), .smp_vld(smp_vld),
  .att_code(att_code), .init_busy(init_busy)
);

// File: tb/spk_limiter_ctrl_test.sv
module spk_limiter_ctrl_test;
  localparam int DW = 16, ATT_MAX = 12, ATT_W = 4, LIM = 2, REC = 32, INIT = 32;
  localparam int HI = 26028, LO = 20675;

  logic clk = 0, rst_n = 0, pd_n = 0, amp_en = 0, smp_vld = 0;
  logic [DW-1:0] smp_data = '0;
  logic [ATT_W-1:0] att_code;
  logic init_busy;

  spk_limiter_ctrl #(.DW(DW), .ATT_MAX(ATT_MAX), .ATT_W(ATT_W), .LIM_PERIOD(LIM),
    .REC_PERIOD(REC), .INIT_LEN(INIT), .HI_THR(HI), .LO_THR(LO)) uut (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .amp_en(amp_en), .smp_vld(smp_vld),
    .smp_data(smp_data), .att_code(att_code), .init_busy(init_busy));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference
  int m_att = 0, m_run = 0, m_init = 0, m_lim = 0, m_rec = 0, m_wait = 0, m_neg = 0;
  always @(posedge clk) begin
    if (!rst_n || !(pd_n && amp_en)) begin
      m_att = 0; m_run = 0; m_init = 0; m_lim = 0; m_rec = 0; m_wait = 0; m_neg = 0;
    end else if (m_run == 0) begin
      if (smp_vld) begin
        m_init++;
        if (m_init == INIT) begin m_run = 1; m_init = 0; end
      end
    end else if (smp_vld) begin
      int v, a, zc;
      v = $signed(smp_data);
      a = (v < 0) ? -v : v;
      if (a > 32767) a = 32767;
      zc = (v == 0) || ((v < 0) != (m_neg != 0));
      m_neg = (v < 0);
      if (a >= HI) begin
        if (m_lim == 0 && m_att < ATT_MAX) m_att++;
        m_lim = (m_lim + 1) % LIM;
      end else m_lim = 0;
      if (a < LO && m_att > 0) begin
        if (m_rec < REC - 1) m_rec++;
        else if (zc || m_wait == REC - 1) begin
          m_att = (m_att > 1) ? m_att - 2 : 0; m_rec = 0; m_wait = 0;
        end else m_wait++;
      end else begin m_rec = 0; m_wait = 0; end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      chk(int'(att_code) == m_att, cur_req, att_code, m_att);
      chk(init_busy == (m_run == 0), cur_req, init_busy, m_run == 0);
    end
    if (cycles > 200000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic send(input int d);
    @(negedge clk); smp_vld = 1; smp_data = DW'(d);
    @(negedge clk); smp_vld = 0;
  endtask

  task automatic expect_out(input int att, input int busy, input string req);
    chk(int'(att_code) == att, req, att_code, att);
    chk(int'(init_busy) == busy, req, init_busy, busy);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_out(0, 1, "R1");
    rst_n = 1;
    @(negedge clk); pd_n = 1; amp_en = 1;
    cur_req = "R2";
    for (int i = 0; i < INIT - 1; i++) send((i % 2) ? 30000 : -30000);
    expect_out(0, 1, "R2");
    send(30000);
    expect_out(0, 0, "R2");

    cur_req = "R4";
    send(30000);  expect_out(1, 0, "R4");
    send(-30000); send(-32768);
    expect_out(2, 0, "R3");
    send(30000); send(26028);
    expect_out(3, 0, "R3");
    cur_req = "R5";
    for (int i = 0; i < 40; i++) send((i % 2) ? 31000 : -31000);
    expect_out(12, 0, "R5");

    cur_req = "R6";
    for (int i = 0; i < 100; i++) send((i % 3 == 0) ? 20675 : ((i % 2) ? 23000 : -26027));
    expect_out(12, 0, "R6");

    cur_req = "R8";
    for (int i = 0; i < REC - 1; i++) send((i % 2) ? 0 : 1000);
    expect_out(12, 0, "R8");
    send(0);
    expect_out(10, 0, "R8");

    cur_req = "R7";
    for (int i = 0; i < REC; i++) send((i % 2) ? 1000 : -1000);
    expect_out(8, 0, "R7");

    cur_req = "R9";
    for (int i = 0; i < 2 * REC - 2; i++) send(1000);
    expect_out(8, 0, "R9");
    send(1000);
    expect_out(6, 0, "R9");

    cur_req = "R10";
    for (int k = 0; k < 3; k++)
      for (int i = 0; i < REC; i++) send((i % 2) ? 1000 : -1000);
    expect_out(0, 0, "R10");
    for (int i = 0; i < 2 * REC; i++) send((i % 2) ? 500 : -500);
    expect_out(0, 0, "R10");

    cur_req = "R11";
    send(30000); send(30000); send(30000);
    expect_out(2, 0, "R11");
    @(negedge clk); amp_en = 0;
    @(negedge clk);
    expect_out(0, 1, "R11");
    amp_en = 1;
    for (int i = 0; i < INIT - 1; i++) send(30000);
    expect_out(0, 1, "R11");
    send(30000);
    expect_out(0, 0, "R11");
    send(30000);
    expect_out(1, 0, "R11");
    @(negedge clk); pd_n = 0;
    @(negedge clk);
    expect_out(0, 1, "R11");
    send(30000);
    expect_out(0, 1, "R11");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule